// File: doc/BRIEF.md
# Keyed-Service System Watchdog

This block is a system watchdog counter that advances on a crystal-derived timing enable. Once armed, it must be serviced at regular intervals by software. Servicing takes two ordered writes to a service register: 0x00A5 followed by 0x005A. A second ordered pair on the same register, 0x0123 followed by 0x0321, requests a software reset at any time. Any write that does not continue the sequence in progress aborts that sequence. If such a write is itself a valid opening key, it starts a new sequence instead.

A small control register holds three fields: a 2-bit timeout selector, a 2-bit expiry-action selector and an arming bit. The arming bit is write-once. Once it is set, the whole control register is frozen until the next system reset.

When the count runs out, the block does one of the following, according to the action field:
- raises a held interrupt request;
- raises a held fast interrupt request;
- emits a one-cycle reset request;
- does nothing.

A status flag survives system reset and records that the most recent system reset followed a watchdog expiry. Only the power-on reset clears that flag unconditionally.

Top module: `wdog_keyed`

## Requirements
- R1: After power-on and system reset, `irq_req`, `fiq_req`, `rst_req` and `last_rst_wdog` are 0 and the control register reads 0.
- R2: The control register is written when `reg_sel`=0, using the field positions timeout [1:0], action [3:2] and arm [4]. While arm is 0, every field is writable. Once arm reads 1, all control writes are ignored until system reset.
- R3: Timeout codes 0, 1, 2 and 3 select periods of 2^T0_LOG, 2^T1_LOG, 2^T2_LOG and 2^T3_LOG counted cycles; the defaults are 20, 22, 24 and 25. A cycle is counted only when the block is armed and `tick_en`=1. An output appears exactly one period after arming, counted in ticks.
- R4: The action codes are: 0 raises `irq_req`, 1 raises `fiq_req`, 2 pulses `rst_req`, and 3 has no effect.
- R5: `irq_req` or `fiq_req`, once raised, stays high until a completed service sequence. After each expiry the counter restarts from zero, so expiries recur once every period.
- R6: Writing 0x00A5 and then 0x005A to the service register (`reg_sel`=1) clears the counter and clears `irq_req` and `fiq_req`. A service completed in the same cycle as an expiry wins, and that expiry is suppressed.
- R7: Writing 0x0123 and then 0x0321 to the service register makes `rst_req` high for exactly the cycle after the second write. This works whether or not the block is armed.
- R8: A service write that does not continue the current sequence aborts it. If that write is 0x00A5 or 0x0123, it opens a new sequence of the matching kind.
- R9: `last_rst_wdog` is updated on the first cycle of each system reset. It becomes 1 if an action-2 expiry occurred since the previous update, and 0 otherwise; a software reset request does not count. It is otherwise stable, and power-on reset clears it.
- R10: A read with `reg_sel`=1 returns 0. A read with `reg_sel`=0 returns the control fields zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | System reset, active low, asynchronous |
| tick_en | input | 1 | Crystal-derived count enable |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = service register |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for the selected register |
| irq_req | output | 1 | Held interrupt request |
| fiq_req | output | 1 | Held fast interrupt request |
| rst_req | output | 1 | One-cycle reset request |
| last_rst_wdog | output | 1 | Last system reset followed a watchdog expiry |

## Verification
The embedded properties check the following on every cycle:
- the arm bit and the control fields stay frozen while armed;
- the counter holds while disarmed;
- the two interrupt requests are never high together, and each is held until a service;
- a completed service clears the count and both requests, and a completed reset key produces a request on the next cycle;
- the sticky flag changes only during system reset.

The bench sweeps every timeout code against every active action code and measures the exact expiry latency. Only those bench scenarios can show:
- the exact period lengths, including under gated and alternating ticks;
- the priority of a service over a same-cycle expiry;
- the abort and restart rules of the key decoder;
- the no-op action;
- the behaviour of the flag across successive system and power-on resets.

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int T0_LOG = 20,
  parameter int T1_LOG = 22,
  parameter int T2_LOG = 24,
  parameter int T3_LOG = 25,
  parameter int DW     = 16
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_req,
  output logic          fiq_req,
  output logic          rst_req,
  output logic          last_rst_wdog
);
  localparam int CW = T3_LOG;
  localparam logic [CW-1:0] LIM0 = {CW{1'b1}} >> (CW - T0_LOG);
  localparam logic [CW-1:0] LIM1 = {CW{1'b1}} >> (CW - T1_LOG);
  localparam logic [CW-1:0] LIM2 = {CW{1'b1}} >> (CW - T2_LOG);
  localparam logic [CW-1:0] LIM3 = {CW{1'b1}} >> (CW - T3_LOG);
  localparam logic [DW-1:0] SVC_K1 = DW'(16'h00A5);
  localparam logic [DW-1:0] SVC_K2 = DW'(16'h005A);
  localparam logic [DW-1:0] SRT_K1 = DW'(16'h0123);
  localparam logic [DW-1:0] SRT_K2 = DW'(16'h0321);

  typedef enum logic [1:0] {K_IDLE, K_SVC, K_SRT} kstate_t;

  logic          armed_q;
  logic [1:0]    tmo_q, act_q;
  logic [CW-1:0] cnt_q, lim;
  kstate_t       ks_q, ks_d;
  logic          pend_q, flag_q, rstn_prev_q;

  wire svc_wr   = reg_wr & reg_sel;
  wire ctl_wr   = reg_wr & ~reg_sel;
  wire svc_done = svc_wr && ks_q == K_SVC && reg_wdata == SVC_K2;
  wire srt_done = svc_wr && ks_q == K_SRT && reg_wdata == SRT_K2;
  wire step     = armed_q & tick_en;
  wire at_lim   = cnt_q == lim;
  wire expire   = step && at_lim && !svc_done;

  always_comb begin
    case (tmo_q)
      2'd0:    lim = LIM0;
      2'd1:    lim = LIM1;
      2'd2:    lim = LIM2;
      default: lim = LIM3;
    endcase
  end

  always_comb begin
    ks_d = ks_q;
    if (svc_wr) begin
      if (svc_done || srt_done)  ks_d = K_IDLE;
      else if (reg_wdata == SVC_K1) ks_d = K_SVC;
      else if (reg_wdata == SRT_K1) ks_d = K_SRT;
      else                          ks_d = K_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      tmo_q   <= 2'd0;
      act_q   <= 2'd0;
      ks_q    <= K_IDLE;
      cnt_q   <= '0;
      irq_req <= 1'b0;
      fiq_req <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      ks_q <= ks_d;
      if (ctl_wr && !armed_q) begin
        tmo_q   <= reg_wdata[1:0];
        act_q   <= reg_wdata[3:2];
        armed_q <= reg_wdata[4];
      end
      if (svc_done)  cnt_q <= '0;
      else if (step) cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
      if (svc_done) begin
        irq_req <= 1'b0;
        fiq_req <= 1'b0;
      end else if (expire) begin
        if (act_q == 2'd0) irq_req <= 1'b1;
        if (act_q == 2'd1) fiq_req <= 1'b1;
      end
      rst_req <= (expire && act_q == 2'd2) || srt_done;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pend_q      <= 1'b0;
      flag_q      <= 1'b0;
      rstn_prev_q <= 1'b1;
    end else begin
      rstn_prev_q <= rst_n;
      if (!rst_n && rstn_prev_q) begin
        flag_q <= pend_q;
        pend_q <= 1'b0;
      end else if (rst_n && expire && act_q == 2'd2) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign last_rst_wdog = flag_q;
  assign reg_rdata     = reg_sel ? '0 : DW'({armed_q, act_q, tmo_q});

  assert_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q && $stable(act_q) && $stable(tmo_q));
  assert_hold_disarmed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !svc_done) |=> $stable(cnt_q));
  assert_one_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_req, fiq_req}));
  assert_irq_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !svc_done) |=> irq_req);
  assert_fiq_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_req && !svc_done) |=> fiq_req);
  assert_service_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    svc_done |=> (cnt_q == '0) && !irq_req && !fiq_req);
  assert_soft_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    srt_done |=> rst_req);
  assert_flag_stable_R9: assert property (@(posedge clk) disable iff (!por_n)
    rst_n |=> $stable(flag_q));
endmodule

// File: tb/tb_wdog_keyed.sv
module tb_wdog_keyed;
  localparam int DW = 16;
  int lg[4] = '{3, 4, 5, 6};

  logic clk = 1'b0;
  logic por_n, rst_n, tick_en, reg_wr, reg_sel;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic irq_req, fiq_req, rst_req, last_rst_wdog;
  logic tick_mode, tick_level;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  wdog_keyed #(.T0_LOG(3), .T1_LOG(4), .T2_LOG(5), .T3_LOG(6), .DW(DW)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_en(tick_en),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .fiq_req(fiq_req),
    .rst_req(rst_req), .last_rst_wdog(last_rst_wdog));

  initial tick_en = 1'b1;
  always @(negedge clk) tick_en <= tick_mode ? ~tick_en : tick_level;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [DW-1:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
  endtask

  task automatic sys_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_out(output int n);
    n = 0;
    while (!(irq_req | fiq_req | rst_req) && n < 300) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n, p, bad;
    por_n = 0; rst_n = 0; reg_wr = 0; reg_sel = 0; reg_wdata = '0;
    tick_mode = 0; tick_level = 1;
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    @(negedge clk);
    chk({irq_req, fiq_req, rst_req, last_rst_wdog} == 4'b0, "R1 outputs", {irq_req, fiq_req, rst_req, last_rst_wdog}, 0);
    chk(reg_rdata == 0, "R1 control", reg_rdata, 0);

    for (int t = 0; t < 4; t++) begin
      for (int a = 0; a < 3; a++) begin
        sys_reset();
        wr(1'b0, DW'(16 + a * 4 + t));
        p = 1 << lg[t];
        wait_out(n);
        chk(n == p, "R3 period", n, p);
        chk({irq_req, fiq_req, rst_req} == 3'(4 >> a), "R4 action", {irq_req, fiq_req, rst_req}, 4 >> a);
        repeat (3) @(negedge clk);
        if (a == 2) chk(rst_req == 0, "R4 pulse", rst_req, 0);
        else chk((irq_req | fiq_req) == 1, "R5 held", irq_req | fiq_req, 1);
      end
    end

    sys_reset();
    wr(1'b0, 16'h0018);
    wait_out(n);
    @(negedge clk);
    wait_out(n);
    chk(n == 7, "R5 wrap", n, 7);

    sys_reset();
    wr(1'b0, 16'h000D);
    chk(reg_rdata == 16'h000D, "R2 writable", reg_rdata, 13);
    wr(1'b0, 16'h0012);
    chk(reg_rdata == 16'h0012, "R2 arm", reg_rdata, 18);
    wr(1'b0, 16'h0000);
    chk(reg_rdata == 16'h0012, "R2 clear ignored", reg_rdata, 18);
    wr(1'b0, 16'h001F);
    chk(reg_rdata == 16'h0012, "R2 change ignored", reg_rdata, 18);
    reg_sel = 1'b1; #1;
    chk(reg_rdata == 0, "R10 service read", reg_rdata, 0);
    reg_sel = 1'b0;
    sys_reset();
    chk(reg_rdata == 0, "R2 unlocked by reset", reg_rdata, 0);

    wr(1'b0, 16'h0000);
    repeat (24) @(negedge clk);
    chk(irq_req == 0, "R3 disarmed", irq_req, 0);
    wr(1'b0, 16'h0010);
    wait_out(n);
    chk(n == 8, "R3 disarmed held count", n, 8);

    sys_reset();
    tick_level = 0;
    @(negedge clk);
    wr(1'b0, 16'h0010);
    repeat (24) @(negedge clk);
    chk(irq_req == 0, "R3 gated", irq_req, 0);
    tick_level = 1;
    @(negedge clk);
    wait_out(n);
    chk(n == 7 || n == 8, "R3 resume", n, 8);

    sys_reset();
    tick_mode = 1;
    wr(1'b0, 16'h0010);
    wait_out(n);
    chk(n == 15 || n == 16, "R3 alternate ticks", n, 16);
    tick_mode = 0; tick_level = 1;

    sys_reset();
    wr(1'b0, 16'h001C);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (irq_req | fiq_req | rst_req) bad++;
    end
    chk(bad == 0, "R4 action 3", bad, 0);

    sys_reset();
    wr(1'b0, 16'h0010);
    wait_out(n);
    wr(1'b1, 16'h00A5);
    wr(1'b1, 16'h005A);
    chk(irq_req == 0, "R6 service clears", irq_req, 0);
    wait_out(n);
    chk(n == 8, "R6 counter cleared", n, 8);

    sys_reset();
    wr(1'b0, 16'h0010);
    repeat (6) @(negedge clk);
    wr(1'b1, 16'h00A5);
    wr(1'b1, 16'h005A);
    chk(irq_req == 0, "R6 priority", irq_req, 0);
    wait_out(n);
    chk(n == 8, "R6 priority restart", n, 8);

    wr(1'b1, 16'h00A5);
    wr(1'b1, 16'h0000);
    wr(1'b1, 16'h005A);
    chk(irq_req == 1, "R8 abort", irq_req, 1);
    wr(1'b1, 16'h00A5);
    wr(1'b1, 16'h00A5);
    wr(1'b1, 16'h005A);
    chk(irq_req == 0, "R8 restart", irq_req, 0);
    wait_out(n);
    wr(1'b1, 16'h0123);
    wr(1'b1, 16'h00A5);
    wr(1'b1, 16'h005A);
    chk(irq_req == 0 && rst_req == 0, "R8 switch to service", {irq_req, rst_req}, 0);
    wr(1'b1, 16'h00A5);
    wr(1'b1, 16'h0123);
    wr(1'b1, 16'h0321);
    chk(rst_req == 1, "R7 soft reset", rst_req, 1);
    @(negedge clk);
    chk(rst_req == 0, "R7 one cycle", rst_req, 0);

    sys_reset();
    wr(1'b1, 16'h0123);
    wr(1'b1, 16'h0321);
    chk(rst_req == 1, "R7 disarmed", rst_req, 1);
    sys_reset();
    chk(last_rst_wdog == 0, "R9 soft not counted", last_rst_wdog, 0);

    wr(1'b0, 16'h0018);
    wait_out(n);
    sys_reset();
    chk(last_rst_wdog == 1, "R9 set", last_rst_wdog, 1);
    repeat (5) @(negedge clk);
    chk(last_rst_wdog == 1, "R9 sticky", last_rst_wdog, 1);
    sys_reset();
    chk(last_rst_wdog == 0, "R9 cleared", last_rst_wdog, 0);

    wr(1'b0, 16'h0018);
    wait_out(n);
    sys_reset();
    por_n = 0; rst_n = 0;
    repeat (2) @(negedge clk);
    por_n = 1; rst_n = 1;
    @(negedge clk);
    chk(last_rst_wdog == 0, "R9 power-on", last_rst_wdog, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule